// File: doc/BRIEF.md
# I2C Target Transmitter with Clock Stretching

This block is the target side of an I2C bus when a controller reads from it. It watches SCL and SDA through synchronisers, finds START and STOP, collects the address byte and compares its upper seven bits with a programmable own address. A zero address can also be accepted when general-call response is switched on. When the address matches and the direction bit asks for a read, the block acknowledges. It then sends bytes taken from a one-byte holding register that the host writes. Bytes go out most significant bit first.

The block only pulls the bus lines low. Two outputs request a low on SDA and a low on SCL, and the pads or the bench turn these into open-drain lines. If the holding register is empty when the next byte is due, the block keeps SCL low until the host writes it. Events go to the host through sticky flags: address hit (with a read-direction flag), holding register emptied, controller not-acknowledge, and end of transfer by STOP or repeated START. One interrupt line is the OR of these flags. The host clears each flag by pulsing its bit.

Top module: `i2c_tgt_tx`

## Requirements
- R1: After reset all flags, the interrupt, and both pull-low outputs are 0. The holding register is empty.
- R2: The address byte arrives MSB first. Its first seven bits are compared with `own_addr` and its eighth bit is the direction, where 1 means read. On a match with direction 1, the block pulls SDA low for the ninth clock and sets `st_amatch` and `st_rd`. A mismatch or direction 0 gets no acknowledge and sets no flag.
- R3: The address 0000000 with direction 1 is acknowledged exactly when `gcall_en` is 1.
- R4: After the address acknowledge, SCL is held low until the host writes a byte. That byte then appears on SDA MSB first, and SDA changes only while SCL is low.
- R5: `st_txe` is set when a byte moves from the holding register into the shifter. A host write clears it. It drives `irq` only when `txi_en` is 1.
- R6: If the holding register is empty when the next byte of an acknowledged transfer is due, SCL is held low until the host writes it.
- R7: A high level from the controller in the ninth bit after a data byte sets `st_nack`. After that, SDA stays released for the rest of the transfer, even when a byte is waiting.
- R8: A `flush` pulse empties the holding register, so a byte written before it is never sent.
- R9: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. Either one ends an acknowledged transfer and sets `st_stop`. Traffic that the block did not acknowledge never sets `st_stop`.
- R10: Flags are write-one-to-clear through `clr`: bit 0 clears amatch and rd, bit 1 clears txe, bit 2 clears nack, bit 3 clears stop. Other flags are unaffected. `irq` is the OR of amatch, nack, stop and the gated txe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Programmed target address |
| gcall_en | input | 1 | Accept the all-zero address |
| txi_en | input | 1 | Let `st_txe` raise `irq` |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| flush | input | 1 | Discard the held byte |
| clr | input | 4 | Write-one-to-clear flag strobes |
| st_amatch | output | 1 | Address matched for a read |
| st_rd | output | 1 | Matched transfer is a read |
| st_txe | output | 1 | Holding register emptied into shifter |
| st_nack | output | 1 | Controller did not acknowledge |
| st_stop | output | 1 | Transfer ended by STOP or repeated START |
| irq | output | 1 | Interrupt request |

## Verification
A state machine that loses track of the bit count shows up on the bus within one byte, because the acknowledge pull lands on the wrong clock or the data read back shifts by a bit. A holding register that is wrongly marked full or empty shows up at once. Either SCL is released with stale data, or the line stays low during a window where the controller waits for SCL to rise, and that window is about a hundred clock cycles. Flag logic that sets or clears the wrong bit is visible a few cycles after the event that should have set it, or after the clear pulse, through the flag outputs and `irq`.

// File: rtl/i2c_tgt_tx.sv
module i2c_tgt_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_pull,
  output logic       sda_pull,
  input  logic [6:0] own_addr,
  input  logic       gcall_en,
  input  logic       txi_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       flush,
  input  logic [3:0] clr,
  output logic       st_amatch,
  output logic       st_rd,
  output logic       st_txe,
  output logic       st_nack,
  output logic       st_stop,
  output logic       irq
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_LOAD, S_PRE, S_TX, S_MACK, S_WAIT} st_t;

  st_t        st;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic [7:0] shr, dreg;
  logic [3:0] cnt;
  logic       full, active, nk;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_ev = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
  wire hit      = (shr[7:1] == own_addr) || (gcall_en && shr[7:1] == 7'd0);

  assign sda_pull = (st == S_AACK) | ((st == S_PRE || st == S_TX) & ~shr[7]);
  assign scl_pull = (st == S_LOAD) | (st == S_PRE);
  assign irq      = st_amatch | st_nack | st_stop | (st_txe & txi_en);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      shr <= '0; dreg <= '0; cnt <= '0;
      full <= 1'b0; active <= 1'b0; nk <= 1'b0;
      st_amatch <= 1'b0; st_rd <= 1'b0; st_txe <= 1'b0;
      st_nack <= 1'b0; st_stop <= 1'b0;
    end else begin
      if (clr[0]) begin st_amatch <= 1'b0; st_rd <= 1'b0; end
      if (clr[1]) st_txe  <= 1'b0;
      if (clr[2]) st_nack <= 1'b0;
      if (clr[3]) st_stop <= 1'b0;

      if (start_ev) begin
        st     <= S_ADDR;
        cnt    <= '0;
        active <= 1'b0;
        if (active) st_stop <= 1'b1;
      end else if (stop_ev) begin
        st     <= S_IDLE;
        active <= 1'b0;
        if (active) st_stop <= 1'b1;
      end else begin
        case (st)
          S_ADDR: begin
            if (scl_rise) begin
              shr <= {shr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end
            if (scl_fall && cnt == 4'd8) begin
              if (hit && shr[0]) begin
                st        <= S_AACK;
                active    <= 1'b1;
                st_amatch <= 1'b1;
                st_rd     <= 1'b1;
              end else begin
                st <= S_WAIT;
              end
            end
          end
          S_AACK: if (scl_fall) st <= S_LOAD;
          S_LOAD: if (full) begin
            shr    <= dreg;
            cnt    <= '0;
            full   <= 1'b0;
            st_txe <= 1'b1;
            st     <= S_PRE;
          end
          S_PRE: st <= S_TX;
          S_TX: if (scl_fall) begin
            shr <= {shr[6:0], 1'b1};
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) st <= S_MACK;
          end
          S_MACK: begin
            if (scl_rise) nk <= sda_s;
            if (scl_fall) begin
              if (nk) begin
                st      <= S_WAIT;
                st_nack <= 1'b1;
              end else begin
                st <= S_LOAD;
              end
            end
          end
          default: ;
        endcase
      end

      if (wr_en) begin
        dreg   <= wr_data;
        full   <= 1'b1;
        st_txe <= 1'b0;
      end
      if (flush) full <= 1'b0;
    end

  a_r4_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);
  a_r5_write_clears_txe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !st_txe);
  a_r5_txe_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_txe) |-> $past(st) == S_LOAD);
  a_r7_nack_from_ack_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_nack) |-> $past(st) == S_MACK);
  a_r9_stop_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_stop) |-> $past(active));

endmodule

// File: tb/tb_i2c_tgt_tx.sv
module tb_i2c_tgt_tx;
  localparam int H = 10;
  localparam logic [6:0] OWN = 7'h3C;
  // {addr7, rw, gcall_en, expect_ack, data}
  localparam logic [17:0] VEC [0:5] = '{
    {7'h3C, 1'b1, 1'b0, 1'b1, 8'hA5},
    {7'h3C, 1'b0, 1'b0, 1'b0, 8'h11},
    {7'h3D, 1'b1, 1'b0, 1'b0, 8'h22},
    {7'h00, 1'b1, 1'b1, 1'b1, 8'h5A},
    {7'h00, 1'b1, 1'b0, 1'b0, 8'h33},
    {7'h3C, 1'b1, 1'b1, 1'b1, 8'h81}
  };

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic gcall_en = 0, txi_en = 1, wr_en = 0, flush = 0;
  logic [7:0] wr_data = '0;
  logic [3:0] clr = '0;
  logic scl_pull, sda_pull, st_amatch, st_rd, st_txe, st_nack, st_stop, irq;
  int checks = 0, errors = 0;

  wire scl_bus = scl_m & ~scl_pull;
  wire sda_bus = sda_m & ~sda_pull;

  always #10 clk = ~clk;

  i2c_tgt_tx dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .own_addr(OWN),
    .gcall_en(gcall_en), .txi_en(txi_en), .wr_en(wr_en), .wr_data(wr_data),
    .flush(flush), .clr(clr), .st_amatch(st_amatch), .st_rd(st_rd),
    .st_txe(st_txe), .st_nack(st_nack), .st_stop(st_stop), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up;
    scl_m = 1;
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic m_start;
    sda_m = 1; hw(H); scl_up; hw(H);
    sda_m = 0; hw(H);
    scl_m = 0;
  endtask

  task automatic m_stop;
    sda_m = 0; hw(H); scl_up; hw(H);
    sda_m = 1; hw(H);
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; hw(H); scl_up; hw(H / 2);
    r = sda_bus; hw(H / 2);
    scl_m = 0;
  endtask

  task automatic m_addr(input logic [6:0] a, input logic rw, output logic ack);
    logic r;
    for (int i = 6; i >= 0; i--) m_bit(a[i], r);
    m_bit(rw, r);
    m_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic m_read(input logic nack, output logic [7:0] d);
    logic r;
    for (int i = 0; i < 8; i++) begin
      m_bit(1'b1, r);
      d = {d[6:0], r};
    end
    m_bit(nack, r);
  endtask

  task automatic h_write(input logic [7:0] d);
    wr_data = d; wr_en = 1; @(negedge clk); wr_en = 0;
  endtask

  task automatic h_clr(input logic [3:0] m);
    clr = m; @(negedge clk); clr = '0;
  endtask

  task automatic h_flush;
    flush = 1; @(negedge clk); flush = 0;
  endtask

  task automatic stretch_chk(input string tag);
    hw(H); scl_m = 1; hw(100);
    chk(tag, scl_bus, 1'b0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    hw(3); rst_n = 1; hw(3);
    // R1 reset state
    chk("R1 flags", {st_amatch, st_rd, st_txe, st_nack, st_stop}, 5'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 pulls", {scl_pull, sda_pull}, 2'b0);

    // table walk: R2 R3 R7 R9
    for (int v = 0; v < 6; v++) begin
      gcall_en = VEC[v][9];
      h_write(VEC[v][7:0]);
      m_start;
      m_addr(VEC[v][17:11], VEC[v][10], ack);
      chk($sformatf("R2 R3 ack v%0d", v), ack, VEC[v][8]);
      chk($sformatf("R2 amatch v%0d", v), {st_amatch, st_rd}, {2{VEC[v][8]}});
      if (VEC[v][8]) begin
        m_read(1'b1, d);
        chk($sformatf("R4 data v%0d", v), d, VEC[v][7:0]);
        hw(5);
        chk($sformatf("R7 nack v%0d", v), st_nack, 1'b1);
      end
      m_stop;
      chk($sformatf("R9 stop v%0d", v), st_stop, VEC[v][8]);
      h_clr(4'hF);
      h_flush;
      hw(2);
      chk($sformatf("R10 cleared v%0d", v), irq, 1'b0);
    end
    gcall_en = 0;

    // R4 R5 R6 R7 R8 directed transfer
    txi_en = 0;
    m_start;
    m_addr(OWN, 1'b1, ack);
    chk("R2 ack", ack, 1'b1);
    stretch_chk("R4 stretch first byte");
    h_clr(4'b0001);
    h_write(8'hC3);
    hw(4);
    chk("R5 txe set", st_txe, 1'b1);
    chk("R5 irq gated off", irq, 1'b0);
    txi_en = 1; hw(1);
    chk("R5 irq gated on", irq, 1'b1);
    m_read(1'b0, d);
    chk("R4 byte0", d, 8'hC3);
    stretch_chk("R6 stretch next byte");
    h_write(8'h96);
    hw(2);
    chk("R5 write then load", st_txe, 1'b1);
    m_read(1'b1, d);
    chk("R6 byte1", d, 8'h96);
    hw(5);
    chk("R7 nack flag", st_nack, 1'b1);
    chk("R7 sda released", sda_bus, 1'b1);
    h_write(8'h0F);
    chk("R5 write clears txe", st_txe, 1'b0);
    m_read(1'b1, d);
    chk("R7 no more bytes", d, 8'hFF);
    h_flush;
    m_stop;
    chk("R9 stop after nack", st_stop, 1'b1);

    // R10 selective clear
    h_clr(4'b0100);
    chk("R10 nack cleared", st_nack, 1'b0);
    chk("R10 others kept", {st_amatch, st_stop}, 2'b01);
    chk("R10 irq still", irq, 1'b1);
    h_clr(4'b1000);
    chk("R10 stop cleared", {st_stop, irq}, 2'b00);

    // R8 flushed byte never sent
    m_start;
    m_addr(OWN, 1'b1, ack);
    stretch_chk("R8 flushed register empty");
    h_write(8'h6E);
    m_read(1'b1, d);
    chk("R8 new byte", d, 8'h6E);

    // R9 repeated start ends transfer
    m_start;
    hw(2);
    chk("R9 restart flag", st_stop, 1'b1);
    m_addr(7'h12, 1'b1, ack);
    chk("R2 mismatch after restart", ack, 1'b0);
    m_stop;
    h_clr(4'hF);
    m_start;
    m_addr(7'h12, 1'b1, ack);
    m_stop;
    chk("R9 unaddressed no flag", st_stop, 1'b0);

    finish_run;
  end
endmodule